// File: doc/BRIEF.md
# Single-Entry Tagged Translation Cache

This block holds one cached virtual-to-physical translation for a three-level, 39-bit virtual address scheme. The cached entry records the virtual address, an address-space identifier, a global flag, the physical page base, the raw 64-bit page-table entry, the physical address that entry was read from, and the page level. Level 0 is a 4 KiB page, level 1 a 2 MiB page and level 2 a 1 GiB page. A page walker fills the entry after a successful walk. The access path looks it up before starting a walk.

A lookup is presented for one cycle, and its result appears registered on the next cycle. The result is a hit flag, the physical address, the cached entry and that entry's address. The lookup compares only the virtual bits above the page offset of the cached level, so a superpage matches across its whole span. The identifier compare is skipped for global entries.

The stored entry can be rewritten in place after accessed/dirty bookkeeping. A flush can be filtered by identifier, by address, by both or by neither.

Top module: `utlb_single`

## Requirements
- R1: After a synchronous reset the cache is empty, and every lookup misses until the next fill.
- R2: Lookup results are registered. `lk_hit` rises only in the cycle after `lk_vld` was high, and it stays low when no lookup was requested.
- R3: On a hit, `lk_pa` equals the filled physical address with its low 12+9·level bits cleared, ORed with the same low bits of the lookup address. Level 0, 1 and 2 clear 12, 21 and 30 bits respectively.
- R4: A lookup hits only if bits [38 : 12+9·level] of the lookup address equal those of the cached address. Bits below that boundary are ignored.
- R5: A non-global entry hits only on an equal 16-bit identifier. A global entry (`fill_glb`=1) hits for any identifier.
- R6: A fill overwrites the entry unconditionally and leaves it valid. This holds even when a flush or rewrite is presented in the same cycle, and the new entry serves lookups from the next cycle on.
- R7: A rewrite (`upd_en`) replaces only the cached PTE of a valid entry. Hit behaviour and `lk_pa` are unchanged, a rewrite of an empty cache has no effect, and a flush in the same cycle takes precedence.
- R8: A flush with both filters off empties the cache.
- R9: A flush filtered only by identifier removes a non-global entry whose identifier equals `fl_asid`. It never removes a global entry.
- R10: A flush filtered only by address removes the entry when `fl_va` falls in the cached page under the rule of R4, whatever the identifier or global flag.
- R11: A flush with both filters removes the entry only when the R9 condition and the R10 condition both hold.
- R12: On a miss, `lk_pa`, `lk_pte` and `lk_pte_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vld | input | 1 | Lookup request |
| lk_asid | input | 16 | Lookup address-space identifier |
| lk_va | input | 39 | Lookup virtual address |
| lk_hit | output | 1 | Registered hit flag |
| lk_pa | output | 56 | Registered translated physical address |
| lk_pte | output | 64 | Registered cached PTE on hit |
| lk_pte_addr | output | 56 | Registered PTE physical address on hit |
| fill_en | input | 1 | Write a new entry |
| fill_asid | input | 16 | Identifier of the new entry |
| fill_va | input | 39 | Virtual address of the new entry |
| fill_pa | input | 56 | Physical address from the walk |
| fill_pte | input | 64 | Leaf PTE |
| fill_pte_addr | input | 56 | Physical address of the leaf PTE |
| fill_lvl | input | 2 | Page level, 0 to 2 |
| fill_glb | input | 1 | Global mapping flag |
| upd_en | input | 1 | Rewrite cached PTE |
| upd_pte | input | 64 | New PTE value |
| fl_en | input | 1 | Flush request |
| fl_by_asid | input | 1 | Apply identifier filter |
| fl_asid | input | 16 | Flush identifier |
| fl_by_va | input | 1 | Apply address filter |
| fl_va | input | 39 | Flush virtual address |

## Verification
The assertions take for granted that `fill_lvl` never exceeds 2. They also assume every control input is a known 0 or 1 from the first clock edge, so that the registered-hit and flush-outcome properties have defined history. The stimulus fills only levels 0 to 2 and holds every request input low outside its own one-cycle pulse. It drives each request at the falling edge, so flush, fill and rewrite collisions occur only where a test sets them up on purpose.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

  // Low-order offset mask for a page of the given level.
  function automatic logic [63:0] span_mask(input int unsigned lvl,
                                            input int unsigned pg_bits,
                                            input int unsigned lvl_bits);
    return (64'd1 << (pg_bits + lvl_bits * lvl)) - 64'd1;
  endfunction

endpackage

// File: rtl/utlb_tagcmp.sv
module utlb_tagcmp import utlb_pkg::*; #(
  parameter int ASID_W       = 16,
  parameter int VA_W         = 39,
  parameter int LVL_W        = 2,
  parameter int PG_BITS      = 12,
  parameter int LVL_BITS     = 9,
  parameter bit GLB_WILDCARD = 1'b1
) (
  input  logic [VA_W-1:0]   e_va,
  input  logic [ASID_W-1:0] e_asid,
  input  logic [LVL_W-1:0]  e_lvl,
  input  logic              e_glb,
  input  logic [VA_W-1:0]   q_va,
  input  logic [ASID_W-1:0] q_asid,
  input  logic              use_asid,
  input  logic              use_va,
  output logic              match
);
  logic [VA_W-1:0] ofs_m;
  logic            tag_eq;
  logic            asid_eq;
  logic            asid_ok;

  assign ofs_m   = VA_W'(span_mask(32'(e_lvl), PG_BITS, LVL_BITS));
  assign tag_eq  = ((e_va ^ q_va) & ~ofs_m) == '0;
  assign asid_eq = (e_asid == q_asid);

  generate
    if (GLB_WILDCARD) begin : g_lookup
      assign asid_ok = e_glb | asid_eq;
    end else begin : g_flush
      assign asid_ok = ~e_glb & asid_eq;
    end
  endgenerate

  assign match = (~use_asid | asid_ok) & (~use_va | tag_eq);
endmodule

// File: rtl/utlb_entry.sv
module utlb_entry import utlb_pkg::*; #(
  parameter int ASID_W   = 16,
  parameter int VA_W     = 39,
  parameter int PA_W     = 56,
  parameter int PTE_W    = 64,
  parameter int LVL_W    = 2,
  parameter int PG_BITS  = 12,
  parameter int LVL_BITS = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_en,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [VA_W-1:0]   fill_va,
  input  logic [PA_W-1:0]   fill_pa,
  input  logic [PTE_W-1:0]  fill_pte,
  input  logic [PA_W-1:0]   fill_pte_addr,
  input  logic [LVL_W-1:0]  fill_lvl,
  input  logic              fill_glb,
  input  logic              upd_en,
  input  logic [PTE_W-1:0]  upd_pte,
  input  logic              kill,
  output logic              vld,
  output logic [ASID_W-1:0] asid,
  output logic [VA_W-1:0]   va,
  output logic [PA_W-1:0]   pa,
  output logic [PTE_W-1:0]  pte,
  output logic [PA_W-1:0]   pte_addr,
  output logic [LVL_W-1:0]  lvl,
  output logic              glb
);
  logic [PA_W-1:0] fill_m;
  assign fill_m = PA_W'(span_mask(32'(fill_lvl), PG_BITS, LVL_BITS));

  // Valid bit has reset; payload registers do not need one.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
    end else if (fill_en) begin
      vld <= 1'b1;
    end else if (kill) begin
      vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      asid     <= fill_asid;
      va       <= fill_va;
      pa       <= fill_pa & ~fill_m;
      pte      <= fill_pte;
      pte_addr <= fill_pte_addr;
      lvl      <= fill_lvl;
      glb      <= fill_glb;
    end else if (upd_en && vld && !kill) begin
      pte <= upd_pte;
    end
  end

  // R1
  reset_empty_chk: assert property (@(posedge clk) rst |=> !vld);

  // R6
  fill_valid_chk: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> vld);

  // R7
  upd_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_en && vld && !fill_en && !kill) |=> (vld && pte == $past(upd_pte) && $stable(pa)));
endmodule

// File: rtl/utlb_single.sv
module utlb_single import utlb_pkg::*; #(
  parameter int ASID_W   = 16,
  parameter int VA_W     = 39,
  parameter int PA_W     = 56,
  parameter int PTE_W    = 64,
  parameter int LVL_W    = 2,
  parameter int PG_BITS  = 12,
  parameter int LVL_BITS = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_vld,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VA_W-1:0]   lk_va,
  output logic              lk_hit,
  output logic [PA_W-1:0]   lk_pa,
  output logic [PTE_W-1:0]  lk_pte,
  output logic [PA_W-1:0]   lk_pte_addr,
  input  logic              fill_en,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [VA_W-1:0]   fill_va,
  input  logic [PA_W-1:0]   fill_pa,
  input  logic [PTE_W-1:0]  fill_pte,
  input  logic [PA_W-1:0]   fill_pte_addr,
  input  logic [LVL_W-1:0]  fill_lvl,
  input  logic              fill_glb,
  input  logic              upd_en,
  input  logic [PTE_W-1:0]  upd_pte,
  input  logic              fl_en,
  input  logic              fl_by_asid,
  input  logic [ASID_W-1:0] fl_asid,
  input  logic              fl_by_va,
  input  logic [VA_W-1:0]   fl_va
);
  logic              e_vld;
  logic              e_glb;
  logic [ASID_W-1:0] e_asid;
  logic [VA_W-1:0]   e_va;
  logic [PA_W-1:0]   e_pa;
  logic [PTE_W-1:0]  e_pte;
  logic [PA_W-1:0]   e_pte_addr;
  logic [LVL_W-1:0]  e_lvl;
  logic              lk_match;
  logic              fl_match;
  logic              kill;
  logic [VA_W-1:0]   lk_m;
  logic [PA_W-1:0]   lk_ofs;

  assign kill = fl_en & e_vld & fl_match;

  utlb_entry #(
    .ASID_W(ASID_W), .VA_W(VA_W), .PA_W(PA_W), .PTE_W(PTE_W),
    .LVL_W(LVL_W), .PG_BITS(PG_BITS), .LVL_BITS(LVL_BITS)
  ) u_ent (
    .clk(clk), .rst(rst),
    .fill_en(fill_en), .fill_asid(fill_asid), .fill_va(fill_va),
    .fill_pa(fill_pa), .fill_pte(fill_pte), .fill_pte_addr(fill_pte_addr),
    .fill_lvl(fill_lvl), .fill_glb(fill_glb),
    .upd_en(upd_en), .upd_pte(upd_pte), .kill(kill),
    .vld(e_vld), .asid(e_asid), .va(e_va), .pa(e_pa), .pte(e_pte),
    .pte_addr(e_pte_addr), .lvl(e_lvl), .glb(e_glb)
  );

  utlb_tagcmp #(
    .ASID_W(ASID_W), .VA_W(VA_W), .LVL_W(LVL_W),
    .PG_BITS(PG_BITS), .LVL_BITS(LVL_BITS), .GLB_WILDCARD(1'b1)
  ) u_lk_cmp (
    .e_va(e_va), .e_asid(e_asid), .e_lvl(e_lvl), .e_glb(e_glb),
    .q_va(lk_va), .q_asid(lk_asid), .use_asid(1'b1), .use_va(1'b1),
    .match(lk_match)
  );

  utlb_tagcmp #(
    .ASID_W(ASID_W), .VA_W(VA_W), .LVL_W(LVL_W),
    .PG_BITS(PG_BITS), .LVL_BITS(LVL_BITS), .GLB_WILDCARD(1'b0)
  ) u_fl_cmp (
    .e_va(e_va), .e_asid(e_asid), .e_lvl(e_lvl), .e_glb(e_glb),
    .q_va(fl_va), .q_asid(fl_asid), .use_asid(fl_by_asid), .use_va(fl_by_va),
    .match(fl_match)
  );

  assign lk_m   = VA_W'(span_mask(32'(e_lvl), PG_BITS, LVL_BITS));
  assign lk_ofs = PA_W'(lk_va & lk_m);

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit      <= 1'b0;
      lk_pa       <= '0;
      lk_pte      <= '0;
      lk_pte_addr <= '0;
    end else if (lk_vld && e_vld && lk_match) begin
      lk_hit      <= 1'b1;
      lk_pa       <= e_pa | lk_ofs;
      lk_pte      <= e_pte;
      lk_pte_addr <= e_pte_addr;
    end else begin
      lk_hit      <= 1'b0;
      lk_pa       <= '0;
      lk_pte      <= '0;
      lk_pte_addr <= '0;
    end
  end

  // R2
  hit_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> $past(lk_vld));

  // R12
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_pa == '0 && lk_pte == '0 && lk_pte_addr == '0));

  // R8
  flush_all_chk: assert property (@(posedge clk) disable iff (rst)
    (fl_en && !fl_by_asid && !fl_by_va && !fill_en) |=> !e_vld);

  // R9
  glb_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (fl_en && fl_by_asid && e_vld && e_glb && !fill_en) |=> e_vld);
endmodule

// File: tb/sim_utlb_single.sv
module sim_utlb_single;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_vld = 1'b0;
  logic [15:0] lk_asid = '0;
  logic [38:0] lk_va = '0;
  logic        lk_hit;
  logic [55:0] lk_pa;
  logic [63:0] lk_pte;
  logic [55:0] lk_pte_addr;
  logic        fill_en = 1'b0;
  logic [15:0] fill_asid = '0;
  logic [38:0] fill_va = '0;
  logic [55:0] fill_pa = '0;
  logic [63:0] fill_pte = '0;
  logic [55:0] fill_pte_addr = '0;
  logic [1:0]  fill_lvl = '0;
  logic        fill_glb = 1'b0;
  logic        upd_en = 1'b0;
  logic [63:0] upd_pte = '0;
  logic        fl_en = 1'b0;
  logic        fl_by_asid = 1'b0;
  logic [15:0] fl_asid = '0;
  logic        fl_by_va = 1'b0;
  logic [38:0] fl_va = '0;

  always #5 clk = ~clk;

  utlb_single u0 (.*);

  int n_run = 0;
  int n_fail = 0;

  // Reference state from the requirements
  logic        m_vld = 1'b0;
  logic [15:0] m_asid;
  logic [38:0] m_va;
  logic [55:0] m_pa;
  logic [63:0] m_pte;
  logic [55:0] m_paddr;
  int          m_lvl = 0;
  logic        m_glb;

  function automatic logic [63:0] bmask(int lvl);
    return (64'd1 << (12 + 9 * lvl)) - 64'd1;
  endfunction

  function automatic logic in_page(logic [38:0] v);
    logic [63:0] mk = bmask(m_lvl);
    return ((({25'b0, v} ^ {25'b0, m_va}) & ~mk) == 64'd0);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic lookup(input string tag, input logic [38:0] v, input logic [15:0] a);
    logic        eh;
    logic [63:0] mk;
    @(negedge clk);
    lk_vld = 1'b1; lk_va = v; lk_asid = a;
    @(negedge clk);
    lk_vld = 1'b0;
    mk = bmask(m_lvl);
    eh = m_vld && in_page(v) && (m_glb || a == m_asid);
    check({tag, " hit"}, {63'b0, lk_hit}, {63'b0, eh});
    if (eh) begin
      check({tag, " R3 pa"}, {8'b0, lk_pa}, ({8'b0, m_pa} & ~mk) | ({25'b0, v} & mk));
      check({tag, " pte"}, lk_pte, m_pte);
      check({tag, " pte_addr"}, {8'b0, lk_pte_addr}, {8'b0, m_paddr});
    end else begin
      check({tag, " R12 zero"}, {8'b0, lk_pa} | lk_pte | {8'b0, lk_pte_addr}, 64'd0);
    end
  endtask

  task automatic drive_fill(input logic [38:0] v, input logic [15:0] a, input logic [55:0] p,
                            input logic [63:0] e, input logic [55:0] ea, input int lvl, input logic g);
    fill_en = 1'b1; fill_va = v; fill_asid = a; fill_pa = p; fill_pte = e;
    fill_pte_addr = ea; fill_lvl = 2'(lvl); fill_glb = g;
    m_vld = 1'b1; m_va = v; m_asid = a; m_pa = 56'({8'b0, p} & ~bmask(lvl));
    m_pte = e; m_paddr = ea; m_lvl = lvl; m_glb = g;
  endtask

  task automatic do_fill(input logic [38:0] v, input logic [15:0] a, input logic [55:0] p,
                         input logic [63:0] e, input logic [55:0] ea, input int lvl, input logic g);
    @(negedge clk);
    drive_fill(v, a, p, e, ea, lvl, g);
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic do_flush(input logic ua, input logic [15:0] a, input logic uv, input logic [38:0] v);
    @(negedge clk);
    fl_en = 1'b1; fl_by_asid = ua; fl_asid = a; fl_by_va = uv; fl_va = v;
    if (m_vld && (!ua || (!m_glb && a == m_asid)) && (!uv || in_page(v))) m_vld = 1'b0;
    @(negedge clk);
    fl_en = 1'b0;
  endtask

  localparam logic [38:0] VA0 = 39'h12_3456_789A;
  localparam logic [15:0] AS0 = 16'h00A5;
  localparam logic [55:0] PA0 = 56'hAB_CDEF_0123_4567;

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: empty after reset
    lookup("R1 empty", VA0, AS0);
    lookup("R1 empty2", 39'd0, 16'd0);
    // R7: rewrite of empty cache has no effect
    @(negedge clk); upd_en = 1'b1; upd_pte = 64'hDEAD; @(negedge clk); upd_en = 1'b0;
    lookup("R7 upd-empty", VA0, AS0);

    for (int lvl = 0; lvl < 3; lvl++) begin
      for (int g = 0; g < 2; g++) begin
        int sh = 12 + 9 * lvl;
        do_fill(VA0, AS0, PA0, 64'hC0DE_0000 + 64'(lvl * 2 + g), 56'h8000 + 56'(lvl), lvl, g[0]);
        // R2: no request, no hit
        @(negedge clk);
        check("R2 idle", {63'b0, lk_hit}, 64'd0);
        lookup("R3 same", VA0, AS0);
        lookup("R3 offset", VA0 ^ (39'd1 << (sh - 1)), AS0);
        lookup("R4 above", VA0 ^ (39'd1 << sh), AS0);
        lookup("R4 top", VA0 ^ (39'd1 << 38), AS0);
        lookup("R5 asid", VA0, AS0 ^ 16'h0100);
        for (int fa = 0; fa < 2; fa++) begin
          for (int fv = 0; fv < 2; fv++) begin
            for (int ad = 0; ad < 2; ad++) begin
              for (int vd = 0; vd < 2; vd++) begin
                string tg;
                tg = (fa == 0 && fv == 0) ? "R8" : (fa == 1 && fv == 0) ? "R9" :
                     (fa == 0) ? "R10" : "R11";
                do_fill(VA0, AS0, PA0, 64'h5A5A, 56'h9000, lvl, g[0]);
                do_flush(fa[0], ad ? AS0 ^ 16'h0001 : AS0, fv[0],
                         vd ? VA0 ^ (39'd1 << sh) : VA0 ^ 39'd1);
                lookup({tg, " flush"}, VA0, AS0);
              end
            end
          end
        end
      end
    end

    // R7: rewrite keeps translation, changes PTE
    do_fill(VA0, AS0, PA0, 64'h1111, 56'h4000, 1, 1'b0);
    @(negedge clk); upd_en = 1'b1; upd_pte = 64'h2222_00C3; m_pte = 64'h2222_00C3;
    @(negedge clk); upd_en = 1'b0;
    lookup("R7 rewrite", VA0 ^ 39'h1F_FFFF, AS0);
    // R7: flush beats rewrite in the same cycle
    @(negedge clk); upd_en = 1'b1; upd_pte = 64'h3333; fl_en = 1'b1;
    fl_by_asid = 1'b0; fl_by_va = 1'b0; m_vld = 1'b0;
    @(negedge clk); upd_en = 1'b0; fl_en = 1'b0;
    lookup("R7 flush-priority", VA0, AS0);
    // R6: fill beats flush and rewrite in the same cycle
    @(negedge clk);
    drive_fill(39'h7F_0000_1000, 16'h0042, 56'h12_0000_3000, 64'h4444, 56'h5000, 0, 1'b0);
    fl_en = 1'b1; upd_en = 1'b1; upd_pte = 64'h9999;
    @(negedge clk); fill_en = 1'b0; fl_en = 1'b0; upd_en = 1'b0;
    lookup("R6 fill-wins", 39'h7F_0000_1ABC, 16'h0042);
    // R6: new fill replaces old mapping
    do_fill(39'h01_0000_0000, 16'h0042, 56'h33_0000_0000, 64'h5555, 56'h6000, 2, 1'b0);
    lookup("R6 old-gone", 39'h7F_0000_1ABC, 16'h0042);
    lookup("R6 new", 39'h01_2345_6789, 16'h0042);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule